// File: doc/BRIEF.md
# Serial Frame Start Condition Detector

This block decides when a serial receiver or transmitter may begin shifting a data word. It watches an asynchronous frame-sync line, synchronises it, samples it on each bit-clock enable and tests the start condition chosen by a 4-bit mode input. The condition can be a level, an edge, a change of the line, a start event from the channel running in the opposite direction, a free-running restart, or a match between the most recent sync bits and a programmed compare word.

Once the condition is met, the block can wait a programmable number of bit-clock enables before it raises a single-cycle start pulse. It then stays busy until the data shifter reports that the transfer has ended. In compare-word mode a stop option keeps the channel restarting after each transfer until a second compare word is seen. Two sticky flags record compare matches until status is read.

Top module: `frame_start_detect`

## Requirements
- R1: After reset `start_pulse`, `busy`, `cmp0_hit` and `cmp1_hit` are all 0.
- R2: Mode 0 (free run) starts at the first bit-clock enable after `enable` rises, and again at the first bit-clock enable after each `xfer_done`.
- R3: Mode 1 starts at the first bit-clock enable at or after a `peer_start` pulse, which may arrive on any clock cycle.
- R4: Modes 2 and 3 start at a bit-clock enable when the synchronised frame-sync level is low (mode 2) or high (mode 3). The synchroniser adds two clock cycles of latency.
- R5: Modes 4 and 5 start when the frame-sync sample taken at this bit-clock enable differs from the sample taken at the previous one: high to low for mode 4, low to high for mode 5. Changes between enables are not seen on their own.
- R6: Mode 7 starts on any difference between consecutive bit-enable samples. Mode 6 starts when the sampled level differs from the level captured at the last start (or held while disabled), so a change that happened during a transfer still starts the next one.
- R7: Mode 8 starts when the last `sync_len`+1 frame-sync samples taken since enable equal the low `sync_len`+1 bits of `cmp0`. The oldest of these samples is compared with bit `sync_len` and the newest with bit 0. Higher compare bits are ignored.
- R8: A nonzero `dly` of D makes the start pulse follow the bit-clock enable that detected the condition by exactly D further bit-clock enables, in every mode including mode 1. `busy` is high during the wait.
- R9: In mode 8 with `stop_mode` = 0, each compare-0 match gives one transfer. After `xfer_done` the block waits for a new match.
- R10: In mode 8 with `stop_mode` = 1, a compare-0 start enters a continuous run that restarts at the first bit-clock enable after each `xfer_done`. The run ends when the recent samples match `cmp1` (same width and order as R7).
- R11: `cmp0_hit` and `cmp1_hit` are set on compare-0 and compare-1 matches in mode 8. They stay set until a `status_rd` cycle clears them.
- R12: Dropping `enable` clears `busy` on the next clock, cancels any pending delay or continuous run, and prevents the start pulse.
- R13: Mode values 9 to 15 never produce a start pulse.
- R14: `start_pulse` lasts one clock cycle. `busy` is high from the start pulse until `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one cycle per serial bit |
| enable | input | 1 | Channel enable |
| fsync_in | input | 1 | Asynchronous frame-sync line |
| mode | input | 4 | Start condition selector (0..8 used) |
| dly | input | 8 | Start delay in bit-clock enables |
| stop_mode | input | 1 | Continuous run until compare 1 (mode 8) |
| sync_len | input | 4 | Compared sync bits minus one |
| cmp0 | input | 16 | Compare word that starts a transfer |
| cmp1 | input | 16 | Compare word that stops a continuous run |
| peer_start | input | 1 | Start event from the opposite channel |
| xfer_done | input | 1 | Data transfer finished |
| status_rd | input | 1 | Status read, clears sticky flags |
| start_pulse | output | 1 | One-cycle start of transfer |
| busy | output | 1 | Delay or transfer in progress |
| cmp0_hit | output | 1 | Sticky compare-0 match |
| cmp1_hit | output | 1 | Sticky compare-1 match |

## Verification
The hardest state to reach from the ports is the end of a continuous compare run. To get there, a compare-0 word is streamed first. The run must then restart after each completion, and the compare-1 word has to arrive bit by bit while a transfer is active, with no intermediate window that matches either word. The bench builds that stream by hand. It then checks that the next idle bit-clock enable brings no restart. Random compare words, widths, prefixes and delays are also streamed into mode 8, and a bench function locates the first matching window to predict the exact pulse position.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    typedef enum logic [3:0] {
        SM_FREE   = 4'd0,
        SM_PEER   = 4'd1,
        SM_LOW    = 4'd2,
        SM_HIGH   = 4'd3,
        SM_FALL   = 4'd4,
        SM_RISE   = 4'd5,
        SM_CHANGE = 4'd6,
        SM_EDGE   = 4'd7,
        SM_WORD   = 4'd8
    } start_mode_e;

    typedef struct packed {
        logic now;
        logic prev;
    } fs_smp_t;

    function automatic logic mode_is_word(input logic [3:0] m);
        return m == SM_WORD;
    endfunction

endpackage

// File: rtl/fsd_sampler.sv
module fsd_sampler
    import fsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CMP_W       = 16,
    localparam int FILL_W     = $clog2(CMP_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              enable,
    input  logic              fsync_in,
    output fs_smp_t           smp,
    output logic [CMP_W-1:0]  window,
    output logic [FILL_W-1:0] fill
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic [CMP_W-1:0]       win_q;
    logic [FILL_W-1:0]      fill_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], fsync_in};
    end

    always_ff @(posedge clk) begin
        if (rst)         prev_q <= 1'b0;
        else if (bit_en) prev_q <= chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (!enable) begin
            fill_q <= '0;
        end else if (bit_en) begin
            win_q <= window;
            if (fill_q != FILL_W'(CMP_W)) fill_q <= fill_q + 1'b1;
        end
    end

    assign smp.now  = chain_q[SYNC_STAGES-1];
    assign smp.prev = prev_q;
    assign window   = {win_q[CMP_W-2:0], chain_q[SYNC_STAGES-1]};
    assign fill     = fill_q;

    a_r5_prev_held: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(prev_q));

endmodule

// File: rtl/fsd_match.sv
module fsd_match #(
    parameter int CMP_W  = 16,
    parameter int LEN_W  = 4,
    parameter int FILL_W = 5
) (
    input  logic [CMP_W-1:0]  window,
    input  logic [CMP_W-1:0]  cmp,
    input  logic [LEN_W-1:0]  len,
    input  logic [FILL_W-1:0] fill,
    output logic              hit
);
    logic [CMP_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < CMP_W; i++) mask[i] = (i <= int'(len));
    end

    assign hit = (fill >= FILL_W'(len)) && (((window ^ cmp) & mask) == '0);

endmodule

// File: rtl/fsd_cond.sv
module fsd_cond
    import fsd_pkg::*;
(
    input  logic [3:0] mode,
    input  fs_smp_t    smp,
    input  logic       arm_lvl,
    input  logic       peer_evt,
    input  logic       cont,
    input  logic       hit0,
    input  logic       hit1,
    output logic       fire
);
    always_comb begin
        case (mode)
            SM_FREE:   fire = 1'b1;
            SM_PEER:   fire = peer_evt;
            SM_LOW:    fire = !smp.now;
            SM_HIGH:   fire = smp.now;
            SM_FALL:   fire = smp.prev && !smp.now;
            SM_RISE:   fire = !smp.prev && smp.now;
            SM_CHANGE: fire = smp.now != arm_lvl;
            SM_EDGE:   fire = smp.now != smp.prev;
            SM_WORD:   fire = cont ? !hit1 : hit0;
            default:   fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsd_seq.sv
module fsd_seq
    import fsd_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             enable,
    input  logic             xfer_done,
    input  logic             peer_start,
    input  logic             fire,
    input  logic             is_word,
    input  logic             stop_mode,
    input  logic             hit1,
    input  logic             fs_now,
    input  logic [DLY_W-1:0] dly,
    output logic             peer_evt,
    output logic             arm_lvl,
    output logic             cont,
    output logic             start_pulse,
    output logic             busy
);
    seq_state_e       state_q;
    logic [DLY_W-1:0] cnt_q;
    logic             cont_q;
    logic             pulse_q;
    logic             peer_q;
    logic             arm_q;
    logic             go;

    assign go = (state_q == ST_IDLE) && bit_en && fire;

    always_ff @(posedge clk) begin
        if (rst || !enable)  peer_q <= 1'b0;
        else if (bit_en)     peer_q <= 1'b0;
        else if (peer_start) peer_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                   arm_q <= 1'b0;
        else if (!enable && bit_en) arm_q <= fs_now;
        else if (enable && go)      arm_q <= fs_now;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cont_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (bit_en && cont_q && (!is_word || hit1)) cont_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (go) begin
                    if (is_word && stop_mode) cont_q <= 1'b1;
                    if (dly == '0) begin
                        state_q <= ST_RUN;
                        pulse_q <= 1'b1;
                    end else begin
                        state_q <= ST_WAIT;
                        cnt_q   <= dly;
                    end
                end
                ST_WAIT: if (bit_en) begin
                    if (cnt_q == DLY_W'(1)) begin
                        state_q <= ST_RUN;
                        pulse_q <= 1'b1;
                    end
                    cnt_q <= cnt_q - 1'b1;
                end
                ST_RUN: if (xfer_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign peer_evt    = peer_q || peer_start;
    assign arm_lvl     = arm_q;
    assign cont        = cont_q;
    assign start_pulse = pulse_q;
    assign busy        = state_q != ST_IDLE;

    a_r14_pulse_single: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);
    a_r14_pulse_busy: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> busy);
    a_r14_run_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !xfer_done && enable) |=> busy);
    a_r12_cancel: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !start_pulse));
    a_r8_wait_count: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (cnt_q != '0));

endmodule

// File: rtl/fsd_flags.sv
module fsd_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       enable,
    input  logic       is_word,
    input  logic       cont,
    input  logic       status_rd,
    input  logic [1:0] hits,
    output logic       cmp0_hit,
    output logic       cmp1_hit
);
    logic set0, set1;

    assign set0 = bit_en && enable && is_word && hits[0];
    assign set1 = bit_en && enable && is_word && cont && hits[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp0_hit <= 1'b0;
            cmp1_hit <= 1'b0;
        end else begin
            if (set0)           cmp0_hit <= 1'b1;
            else if (status_rd) cmp0_hit <= 1'b0;
            if (set1)           cmp1_hit <= 1'b1;
            else if (status_rd) cmp1_hit <= 1'b0;
        end
    end

    a_r11_hold0: assert property (@(posedge clk) disable iff (rst)
        (cmp0_hit && !status_rd) |=> cmp0_hit);
    a_r11_hold1: assert property (@(posedge clk) disable iff (rst)
        (cmp1_hit && !status_rd) |=> cmp1_hit);

endmodule

// File: rtl/frame_start_detect.sv
module frame_start_detect
    import fsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_W       = 8,
    parameter int CMP_W       = 16,
    localparam int LEN_W      = $clog2(CMP_W),
    localparam int FILL_W     = $clog2(CMP_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             enable,
    input  logic             fsync_in,
    input  logic [3:0]       mode,
    input  logic [DLY_W-1:0] dly,
    input  logic             stop_mode,
    input  logic [LEN_W-1:0] sync_len,
    input  logic [CMP_W-1:0] cmp0,
    input  logic [CMP_W-1:0] cmp1,
    input  logic             peer_start,
    input  logic             xfer_done,
    input  logic             status_rd,
    output logic             start_pulse,
    output logic             busy,
    output logic             cmp0_hit,
    output logic             cmp1_hit
);
    fs_smp_t           smp;
    logic [CMP_W-1:0]  window;
    logic [FILL_W-1:0] fill;
    logic [CMP_W-1:0]  cmp_vals [2];
    logic [1:0]        hits;
    logic              is_word;
    logic              fire, peer_evt, arm_lvl, cont;

    assign is_word     = mode_is_word(mode);
    assign cmp_vals[0] = cmp0;
    assign cmp_vals[1] = cmp1;

    fsd_sampler #(.SYNC_STAGES(SYNC_STAGES), .CMP_W(CMP_W)) u_smp (
        .clk(clk), .rst(rst), .bit_en(bit_en), .enable(enable),
        .fsync_in(fsync_in), .smp(smp), .window(window), .fill(fill)
    );

    for (genvar g = 0; g < 2; g++) begin : g_cmp
        fsd_match #(.CMP_W(CMP_W), .LEN_W(LEN_W), .FILL_W(FILL_W)) u_match (
            .window(window), .cmp(cmp_vals[g]), .len(sync_len),
            .fill(fill), .hit(hits[g])
        );
    end

    fsd_cond u_cond (
        .mode(mode), .smp(smp), .arm_lvl(arm_lvl), .peer_evt(peer_evt),
        .cont(cont), .hit0(hits[0]), .hit1(hits[1]), .fire(fire)
    );

    fsd_seq #(.DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst(rst), .bit_en(bit_en), .enable(enable),
        .xfer_done(xfer_done), .peer_start(peer_start), .fire(fire),
        .is_word(is_word), .stop_mode(stop_mode), .hit1(hits[1]),
        .fs_now(smp.now), .dly(dly), .peer_evt(peer_evt),
        .arm_lvl(arm_lvl), .cont(cont), .start_pulse(start_pulse), .busy(busy)
    );

    fsd_flags u_flags (
        .clk(clk), .rst(rst), .bit_en(bit_en), .enable(enable),
        .is_word(is_word), .cont(cont), .status_rd(status_rd), .hits(hits),
        .cmp0_hit(cmp0_hit), .cmp1_hit(cmp1_hit)
    );

    a_r13_unused_mode: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode > 4'd8) |=> !start_pulse);

endmodule

// File: tb/sim_frame_start_detect.sv
module sim_frame_start_detect;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0, enable = 1'b0, fsync_in = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [7:0]  dly = 8'd0;
    logic        stop_mode = 1'b0;
    logic [3:0]  sync_len = 4'd0;
    logic [15:0] cmp0 = 16'd0, cmp1 = 16'd0;
    logic        peer_start = 1'b0, xfer_done = 1'b0, status_rd = 1'b0;
    logic        start_pulse, busy, cmp0_hit, cmp1_hit;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    frame_start_detect u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .enable(enable),
        .fsync_in(fsync_in), .mode(mode), .dly(dly), .stop_mode(stop_mode),
        .sync_len(sync_len), .cmp0(cmp0), .cmp1(cmp1),
        .peer_start(peer_start), .xfer_done(xfer_done), .status_rd(status_rd),
        .start_pulse(start_pulse), .busy(busy),
        .cmp0_hit(cmp0_hit), .cmp1_hit(cmp1_hit)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic b);
        bit_en = b;
        @(posedge clk);
        #1;
        bit_en = 1'b0; xfer_done = 1'b0; peer_start = 1'b0; status_rd = 1'b0;
    endtask

    task automatic set_fs(input logic v);
        fsync_in = v;
        tick(1'b0);
        tick(1'b0);
    endtask

    task automatic feed_bit(input logic v);
        set_fs(v);
        tick(1'b1);
    endtask

    task automatic restart(input logic [3:0] m);
        enable = 1'b0;
        tick(1'b1);
        mode = m;
        enable = 1'b1;
    endtask

    task automatic expect_after(input int n, input string req);
        int first = 0;
        int cnt = 0;
        for (int i = 1; i <= n + 2; i++) begin
            tick(1'b0);
            tick(1'b1);
            if (start_pulse) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
        chk(req, "start position in bit enables", first, n);
        chk(req, "start pulses", cnt, 1);
    endtask

    function automatic bit win_match(input logic [15:0] w, input logic [15:0] c, input int len);
        for (int i = 0; i <= len; i++) if (w[i] != c[i]) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd4711));
        tick(1'b0); tick(1'b0); tick(1'b0);
        rst = 1'b0;
        tick(1'b0);
        // R1 reset state
        chk("R1", "start_pulse", start_pulse, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "flags", {cmp1_hit, cmp0_hit}, 0);

        // R13 unused mode
        restart(4'd13);
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            fsync_in = i[1];
            tick(1'b1);
            if (start_pulse) cnt++;
        end
        chk("R13", "pulses in mode 13", cnt, 0);

        // R2 free run, R14 busy hold
        restart(4'd0);
        tick(1'b1);
        chk("R2", "first start", start_pulse, 1);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            tick(1'b1);
            if (start_pulse) cnt++;
        end
        chk("R14", "no pulse while busy", cnt, 0);
        chk("R14", "busy during transfer", busy, 1);
        xfer_done = 1'b1; tick(1'b0);
        chk("R14", "busy after done", busy, 0);
        tick(1'b1);
        chk("R2", "restart after done", start_pulse, 1);
        tick(1'b0);
        chk("R14", "pulse width", start_pulse, 0);

        // R3 peer start, R8 delay
        dly = 8'd0;
        restart(4'd1);
        tick(1'b1); tick(1'b1);
        chk("R3", "no start without peer", start_pulse, 0);
        peer_start = 1'b1; tick(1'b0);
        tick(1'b1);
        chk("R3", "start after peer", start_pulse, 1);
        dly = 8'd3;
        restart(4'd1);
        peer_start = 1'b1; tick(1'b0);
        expect_after(4, "R8");

        // R12 cancel during delay
        dly = 8'd5;
        restart(4'd1);
        peer_start = 1'b1; tick(1'b0);
        tick(1'b1); tick(1'b1);
        chk("R8", "busy during delay", busy, 1);
        enable = 1'b0; tick(1'b0);
        chk("R12", "busy after disable", busy, 0);
        enable = 1'b1;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            tick(1'b1);
            if (start_pulse) cnt++;
        end
        chk("R12", "no pulse after cancel", cnt, 0);
        dly = 8'd0;

        // R4 levels
        set_fs(1'b0);
        restart(4'd3);
        tick(1'b1);
        chk("R4", "mode 3 low line", start_pulse, 0);
        set_fs(1'b1); tick(1'b1);
        chk("R4", "mode 3 high line", start_pulse, 1);
        restart(4'd2);
        tick(1'b1);
        chk("R4", "mode 2 high line", start_pulse, 0);
        set_fs(1'b0); tick(1'b1);
        chk("R4", "mode 2 low line", start_pulse, 1);

        // R5 edges
        set_fs(1'b1);
        restart(4'd5);
        tick(1'b1); tick(1'b1);
        chk("R5", "steady high no rise", start_pulse, 0);
        set_fs(1'b0); tick(1'b1);
        chk("R5", "fall in mode 5", start_pulse, 0);
        set_fs(1'b1); tick(1'b1);
        chk("R5", "rise in mode 5", start_pulse, 1);
        restart(4'd4);
        set_fs(1'b0); tick(1'b1);
        chk("R5", "fall in mode 4", start_pulse, 1);

        // R6 edge versus level change
        set_fs(1'b0);
        restart(4'd7);
        set_fs(1'b1); tick(1'b1);
        chk("R6", "mode 7 start", start_pulse, 1);
        set_fs(1'b0); tick(1'b1);
        xfer_done = 1'b1; tick(1'b0);
        tick(1'b1);
        chk("R6", "mode 7 change during run", start_pulse, 0);
        restart(4'd6);
        set_fs(1'b1); tick(1'b1);
        chk("R6", "mode 6 start", start_pulse, 1);
        set_fs(1'b0); tick(1'b1);
        xfer_done = 1'b1; tick(1'b0);
        tick(1'b1);
        chk("R6", "mode 6 change during run", start_pulse, 1);

        // R7 R9 compare word, single shot
        sync_len = 4'd3; cmp0 = 16'h5A5A; stop_mode = 1'b0;
        restart(4'd8);
        cnt = 0;
        feed_bit(1'b1); if (start_pulse) cnt++;
        feed_bit(1'b0); if (start_pulse) cnt++;
        feed_bit(1'b1); if (start_pulse) cnt++;
        chk("R7", "no start on partial word", cnt, 0);
        feed_bit(1'b0);
        chk("R7", "start on full word", start_pulse, 1);
        chk("R11", "cmp0 flag set", cmp0_hit, 1);
        xfer_done = 1'b1; tick(1'b0);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            feed_bit(1'b0);
            if (start_pulse) cnt++;
        end
        chk("R9", "no restart without match", cnt, 0);
        feed_bit(1'b1); feed_bit(1'b0); feed_bit(1'b1); feed_bit(1'b0);
        chk("R9", "start on new match", start_pulse, 1);
        xfer_done = 1'b1; tick(1'b0);
        status_rd = 1'b1; tick(1'b0);

        // R7 R8 random compare words
        for (int it = 0; it < 20; it++) begin
            int len, pre, d, total, m, first, k;
            logic [15:0] bw;
            logic [15:0] cw;
            logic b;
            len = $urandom % 16; pre = $urandom % 6; d = $urandom % 4;
            cw = 16'($urandom);
            sync_len = 4'(len); cmp0 = cw; dly = 8'(d);
            restart(4'd8);
            total = pre + len + 1 + d + 2;
            bw = '0; m = 0; first = 0;
            for (k = 1; k <= total; k++) begin
                if (k <= pre || k > pre + len + 1) b = 1'($urandom);
                else b = cw[len - (k - pre - 1)];
                bw = {bw[14:0], b};
                if (m == 0 && k >= len + 1 && win_match(bw, cw, len)) m = k;
                feed_bit(b);
                if (start_pulse && first == 0) first = k;
            end
            chk("R7", "random word start position", first, m + d);
            xfer_done = 1'b1; tick(1'b0);
        end
        dly = 8'd0;
        status_rd = 1'b1; tick(1'b0);

        // R10 continuous run stopped by compare 1
        sync_len = 4'd3; cmp0 = 16'h000A; cmp1 = 16'hF006; stop_mode = 1'b1;
        restart(4'd8);
        feed_bit(1'b1); feed_bit(1'b0); feed_bit(1'b1); feed_bit(1'b0);
        chk("R10", "compare-0 start", start_pulse, 1);
        xfer_done = 1'b1; tick(1'b0);
        feed_bit(1'b0);
        chk("R10", "continuous restart", start_pulse, 1);
        feed_bit(1'b0); feed_bit(1'b1); feed_bit(1'b1); feed_bit(1'b0);
        chk("R11", "cmp1 flag set", cmp1_hit, 1);
        xfer_done = 1'b1; tick(1'b0);
        feed_bit(1'b0);
        chk("R10", "no restart after compare 1", start_pulse, 0);
        stop_mode = 1'b0;

        // R11 sticky and cleared by read
        tick(1'b0); tick(1'b0);
        chk("R11", "flags sticky", {cmp1_hit, cmp0_hit}, 3);
        status_rd = 1'b1; tick(1'b0);
        chk("R11", "flags cleared by read", {cmp1_hit, cmp0_hit}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule